// File: doc/BRIEF.md
# Single-Entry Pipeline FIFO

This block is a one-slot queue. It holds one data word in a register, with an occupancy flag beside it. A producer offers words on a valid/ready input channel, and a consumer takes them from a valid/ready output channel. While the slot holds a word, the output channel shows it.

The input side accepts a new word in the same cycle as the consumer takes the stored word. This works as though the removal happens first. As a result, a steady stream moves through the single register at one word per clock, with no idle cycle between words.

When the slot is empty, an arriving word is only written. It reaches the output on the next cycle, so there is no combinational path from input data to output data. A synchronous flush empties the slot and takes priority over any write in the same cycle.

Top module: `pipe_slot`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: When the slot is empty and `flush` is 0, `in_ready` is 1. A word with `in_valid`=1 is stored at the clock edge and appears on `out_data` with `out_valid`=1 on the next cycle.
- R3: When the slot is full and `out_ready` is 0, `in_ready` is 0. The offered word is not taken, and `out_valid` and `out_data` stay unchanged.
- R4: When the slot is full, `out_ready`=1 and no word is written, the slot is empty on the next cycle.
- R5: When the slot is full and `out_ready`=1 (with `flush`=0), `in_ready` is 1 in that same cycle. A word offered then replaces the stored word, and `out_valid` stays 1.
- R6: An empty slot never forwards an incoming word in the same cycle: `out_valid` stays 0 in the cycle the word is written.
- R7: `flush`=1 drives `in_ready` to 0 and leaves the slot empty on the next cycle, whether or not a word is offered.
- R8: With `in_valid` and `out_ready` both held at 1, one word is handed over on each side in every cycle.
- R9: Under arbitrary stalls on both sides, words leave in the order they entered, with none lost and none repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empties the slot at the next edge |
| in_valid | input | 1 | Producer offers `in_data` |
| in_ready | output | 1 | Slot will take the offered word |
| in_data | input | WIDTH | Word from the producer |
| out_valid | output | 1 | Slot holds a word |
| out_ready | input | 1 | Consumer takes the held word |
| out_data | output | WIDTH | Held word |

## Verification
The hardest case to reach is the full slot, where the consumer takes a word and the producer offers one in the same cycle. Only in that case does the readiness path through `out_ready` decide whether the stream stalls.

The vector table therefore places a replacement write right after a rejected write, and a later phase holds both sides open for a long run. A final phase drives both handshakes from independent pseudo-random patterns. It compares every departing word against the order of accepted words, so a swap, a drop or a duplicate under stall is caught.

// File: rtl/pipe_slot.sv
module pipe_slot #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_data
);

  logic             held_q;
  logic [WIDTH-1:0] word_q;
  logic             push, pop;

  assign pop       = held_q & out_ready;
  assign in_ready  = ~flush & (~held_q | out_ready);
  assign push      = in_valid & in_ready;
  assign out_valid = held_q;
  assign out_data  = word_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     held_q <= 1'b0;
    else if (flush) held_q <= 1'b0;
    else if (push)  held_q <= 1'b1;
    else if (pop)   held_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (push) word_q <= in_data;
  end

  a_r2_store_shows: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid && out_data == $past(in_data)));

  a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !flush) |=> (out_valid && $stable(out_data)));

  a_r4_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

  a_r5_swap_keeps_full: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && in_valid && !flush) |=> out_valid);

  a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !out_valid);

  a_r3_no_accept_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

endmodule

// File: tb/tb_pipe_slot.sv
`timescale 1ns/1ps
module tb_pipe_slot;
  localparam int W = 8;
  localparam int NV = 13;

  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0, in_valid = 1'b0, out_ready = 1'b0;
  logic [W-1:0] in_data = '0;
  logic in_ready, out_valid;
  logic [W-1:0] out_data;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  pipe_slot #(.WIDTH(W)) dut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data));

  // {req[3:0], flush, in_valid, out_ready, din[7:0], exp_ready, exp_valid, exp_data[7:0]}
  typedef logic [24:0] vec_t;
  localparam vec_t VECS [NV] = '{
    {4'd2, 3'b000, 8'h00, 2'b10, 8'h00},
    {4'd2, 3'b010, 8'hA1, 2'b10, 8'h00},
    {4'd3, 3'b010, 8'hB2, 2'b01, 8'hA1},
    {4'd3, 3'b000, 8'h00, 2'b01, 8'hA1},
    {4'd5, 3'b011, 8'hC3, 2'b11, 8'hA1},
    {4'd5, 3'b011, 8'hD4, 2'b11, 8'hC3},
    {4'd4, 3'b001, 8'h00, 2'b11, 8'hD4},
    {4'd4, 3'b000, 8'h00, 2'b10, 8'h00},
    {4'd6, 3'b011, 8'hE5, 2'b10, 8'h00},
    {4'd7, 3'b110, 8'hF6, 2'b01, 8'hE5},
    {4'd7, 3'b000, 8'h00, 2'b10, 8'h00},
    {4'd7, 3'b110, 8'h77, 2'b00, 8'h00},
    {4'd7, 3'b000, 8'h00, 2'b10, 8'h00}
  };

  function automatic string rname(input int n);
    case (n)
      1: return "R1"; 2: return "R2"; 3: return "R3"; 4: return "R4";
      5: return "R5"; 6: return "R6"; 7: return "R7"; 8: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string r, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  task automatic step_to_sample();
    @(negedge clk); #1;
  endtask

  initial begin
    #20000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    int sent, recv;
    logic [W-1:0] exp_d;
    repeat (3) @(negedge clk);
    #1;
    check("R1", "out_valid in reset", int'(out_valid), 0);
    check("R1", "in_ready in reset", int'(in_ready), 1);
    @(negedge clk); rst_n = 1'b1; #1;
    check("R1", "out_valid after reset", int'(out_valid), 0);
    check("R1", "in_ready after reset", int'(in_ready), 1);

    // vector table, one entry per cycle
    for (int i = 0; i < NV; i++) begin
      {flush, in_valid, out_ready} = VECS[i][20:18];
      in_data = VECS[i][17:10];
      #1;
      check(rname(int'(VECS[i][24:21])), "in_ready", int'(in_ready), int'(VECS[i][9]));
      check(rname(int'(VECS[i][24:21])), "out_valid", int'(out_valid), int'(VECS[i][8]));
      if (VECS[i][8])
        check(rname(int'(VECS[i][24:21])), "out_data", int'(out_data), int'(VECS[i][7:0]));
      @(negedge clk);
    end
    flush = 1'b0; in_valid = 1'b0; out_ready = 1'b0;

    // R8: sustained stream
    in_valid = 1'b1; out_ready = 1'b1; in_data = 8'd0;
    #1;
    for (int k = 0; k < 20; k++) begin
      check("R8", "in_ready streaming", int'(in_ready), 1);
      if (k > 0) begin
        check("R8", "out_valid streaming", int'(out_valid), 1);
        check("R8", "out_data streaming", int'(out_data), k - 1);
      end
      @(negedge clk); in_data = W'(k + 1); #1;
    end
    in_valid = 1'b0;
    @(negedge clk); out_ready = 1'b0;
    @(negedge clk);

    // R9: random stalls on both sides
    lfsr = 16'hACE1; sent = 0; recv = 0;
    while (recv < 200) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      in_valid = lfsr[0] && (sent < 200);
      out_ready = lfsr[5] | lfsr[9];
      in_data = W'(sent);
      #1;
      if (out_valid && out_ready) begin
        exp_d = W'(recv);
        check("R9", "order", int'(out_data), int'(exp_d));
        recv++;
      end
      if (in_valid && in_ready) sent++;
      @(negedge clk);
    end
    check("R9", "all words out", recv, 200);
    in_valid = 1'b0; out_ready = 1'b0;
    #1;
    check("R9", "empty at end", int'(out_valid), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule